// File: doc/BRIEF.md
# Burst-two common-IO SRAM controller

This block sits between a host and a synchronous SRAM that has one bidirectional data bus, a fixed burst of two beats and double-data-rate transfers. A host request carries a read or write flag, a burst address, a tag, two data beats and a per-byte write mask. The request is handed over on a valid/ready interface. The controller places commands on the memory pins only in slots that belong to the rising edge of the main memory clock. It drives write beats one memory cycle after the write command. It collects the two read beats that come back two and a half memory cycles after a read command, and returns them to the host as one word with the tag of the original read.

The design runs in a single clock domain, and every controller clock cycle is one phase slot. Two consecutive slots make one memory clock period: a main-edge slot followed by a complementary-edge slot. The output `sram_kslot` marks the main-edge slots. A reservation map of future slots tracks, for every slot, which side will drive the shared bus. The controller accepts a request only when the request's beats would not fall on the same slot as traffic in the opposite direction, and would not fall directly next to it. A short tag queue matches returned beat pairs to reads strictly in the order they were issued.

Top module: `b2sram_ctrl`

## Requirements
- R1: During and after reset, with no request, `sram_rd_n` and `sram_wr_n` are 1, `sram_dq_oe` is 0, every `sram_bw_n` bit is 1 and `rsp_valid` is 0.
- R2: A command (`sram_rd_n` or `sram_wr_n` low, never both) appears only in a slot where `sram_kslot` is 1. A command slot is always followed by a slot with no command. `req_ready` is 0 in any cycle whose following slot is not a main-edge slot.
- R3: A write accepted in cycle c puts its command on the pins in slot c+1. Beat 0 (`req_wdata[DATA_W-1:0]`) is driven with `sram_dq_oe`=1 in slot c+3, and beat 1 (upper half) in slot c+4. No other slot has `sram_dq_oe`=1.
- R4: In each write beat, `sram_bw_n` is the inverse of that beat's mask slice. Beat 0 uses `req_wmask[NBYTES-1:0]` and beat 1 uses the upper slice. Mask bit i covers byte i, bits `[i*BYTE_W +: BYTE_W]`. A byte with mask bit 0 keeps its old memory contents. When no write beat is driven, all strobes are 1.
- R5: A read accepted in cycle c sets `sram_rd_n` low in slot c+1. The memory returns beat 0 in slot c+6 and beat 1 in slot c+7, with `sram_qvld`=1. `rsp_valid` is 1 in cycle c+8, with beat 0 in `rsp_data[DATA_W-1:0]` and beat 1 in the upper half.
- R6: Responses come back in the same order as the reads were accepted, and each response carries the `req_tag` of its read.
- R7: The controller never drives the bus in a slot where the memory returns data, nor in a slot right before or right after one. When a write is presented right after a read, it is accepted 6 cycles after the read. When a read is presented right after a write, it is accepted 2 cycles after the write.
- R8: Reads presented one after another are accepted every 2 cycles.
- R9: While `req_valid` is 0, no command is issued, for any number of cycles. Operation resumes normally afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, two cycles per memory clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request of the presented kind can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Burst address |
| req_wdata | input | 2*DATA_W | Write beats, beat 0 in the low half |
| req_wmask | input | 2*NBYTES | Active-high byte enables, beat 0 in the low half |
| req_tag | input | TAG_W | Read tag returned with the response |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_data | output | 2*DATA_W | Read beats, beat 0 in the low half |
| rsp_tag | output | TAG_W | Tag of the answered read |
| sram_kslot | output | 1 | Current slot belongs to the main clock rising edge |
| sram_addr | output | ADDR_W | Memory address |
| sram_rd_n | output | 1 | Active-low read command |
| sram_wr_n | output | 1 | Active-low write command |
| sram_dq_out | output | DATA_W | Write beat to the data pads |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_bw_n | output | NBYTES | Active-low byte-write strobes |
| sram_dq_in | input | DATA_W | Data from the pads |
| sram_qvld | input | 1 | Memory marks a returned read beat |

## Verification
The case that matters is a write that is presented in the same window in which the data of an earlier read is still on its way back. The write's data slots and the read's return slots would then land on the same stretch of the shared bus. The bench provokes this by presenting a write in the cycle right after a read is accepted, and again in the reverse order. It judges the outcome two ways: by the cycle spacing between the two accepts (6 cycles and 2 cycles), and by a memory model that, in every slot, flags a drive enable that overlaps or directly adjoins a returned beat. The read-back data then shows that neither transfer was damaged.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;
    // slots from the command slot to the first write beat
    localparam int WR_GAP_SLOTS = 2;
    // slots from the command slot to the first returned read beat
    localparam int RD_GAP_SLOTS = 5;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } cmd_pins_t;
endpackage

// File: rtl/b2sram_sched.sv
module b2sram_sched #(
    parameter int WR_LAT = 2,
    parameter int RD_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tag_full,
    input  logic issue_rd,
    input  logic issue_wr,
    output logic ok_rd,
    output logic ok_wr,
    output logic kslot
);
    // map bit k describes the slot k cycles after the current one
    localparam int WOFS = 1 + WR_LAT;
    localparam int ROFS = 1 + RD_LAT;
    localparam int HOR  = (ROFS > WOFS) ? ROFS + 3 : WOFS + 3;

    typedef struct packed {
        logic           kslot;
        logic [HOR-1:0] host;
        logic [HOR-1:0] mem;
    } st_t;

    st_t q, d;
    logic [HOR-1:0] set_h, set_m;

    always_comb begin
        ok_wr = !q.kslot;
        for (int k = WOFS - 1; k <= WOFS + 2; k++)
            if (q.mem[k]) ok_wr = 1'b0;
        for (int k = WOFS; k <= WOFS + 1; k++)
            if (q.host[k]) ok_wr = 1'b0;

        ok_rd = !q.kslot && !tag_full;
        for (int k = ROFS - 1; k <= ROFS + 2; k++)
            if (q.host[k]) ok_rd = 1'b0;
        for (int k = ROFS; k <= ROFS + 1; k++)
            if (q.mem[k]) ok_rd = 1'b0;

        set_h = '0;
        set_m = '0;
        if (issue_wr) begin
            set_h[WOFS]     = 1'b1;
            set_h[WOFS + 1] = 1'b1;
        end
        if (issue_rd) begin
            set_m[ROFS]     = 1'b1;
            set_m[ROFS + 1] = 1'b1;
        end

        d.host  = (q.host | set_h) >> 1;
        d.mem   = (q.mem | set_m) >> 1;
        d.kslot = !q.kslot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.kslot <= 1'b0;
            q.host  <= '0;
            q.mem   <= '0;
        end else begin
            q <= d;
        end
    end

    assign kslot = q.kslot;
endmodule

// File: rtl/b2sram_wrpipe.sv
module b2sram_wrpipe #(
    parameter int DATA_W = 36,
    parameter int NBYTES = 4,
    parameter int WR_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_wr,
    input  logic [2*DATA_W-1:0]   wdata,
    input  logic [2*NBYTES-1:0]   wmask,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    output logic [NBYTES-1:0]     bw_n
);
    localparam int DEPTH = WR_LAT + 1;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
        logic [NBYTES-1:0] bwn;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] pipe;
        slot_t             out;
    } st_t;

    st_t q, d;

    always_comb begin
        for (int k = 0; k < DEPTH - 1; k++)
            d.pipe[k] = q.pipe[k + 1];
        d.pipe[DEPTH-1].v   = 1'b0;
        d.pipe[DEPTH-1].d   = '0;
        d.pipe[DEPTH-1].bwn = '1;
        if (issue_wr) begin
            d.pipe[WR_LAT-1].v   = 1'b1;
            d.pipe[WR_LAT-1].d   = wdata[DATA_W-1:0];
            d.pipe[WR_LAT-1].bwn = ~wmask[NBYTES-1:0];
            d.pipe[WR_LAT].v     = 1'b1;
            d.pipe[WR_LAT].d     = wdata[2*DATA_W-1:DATA_W];
            d.pipe[WR_LAT].bwn   = ~wmask[2*NBYTES-1:NBYTES];
        end
        d.out = q.pipe[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                q.pipe[k].v   <= 1'b0;
                q.pipe[k].d   <= '0;
                q.pipe[k].bwn <= '1;
            end
            q.out.v   <= 1'b0;
            q.out.d   <= '0;
            q.out.bwn <= '1;
        end else begin
            q <= d;
        end
    end

    assign dq_out = q.out.d;
    assign dq_oe  = q.out.v;
    assign bw_n   = q.out.bwn;
endmodule

// File: rtl/b2sram_rdcap.sv
module b2sram_rdcap #(
    parameter int DATA_W    = 36,
    parameter int TAG_W     = 4,
    parameter int TAG_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_rd,
    input  logic [TAG_W-1:0]    issue_tag,
    input  logic [DATA_W-1:0]   dq_in,
    input  logic                qvld,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic                tag_full
);
    // TAG_DEPTH is a power of two so pointers wrap on their own
    localparam int PTR_W = (TAG_DEPTH > 1) ? $clog2(TAG_DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [TAG_DEPTH-1:0][TAG_W-1:0] tags;
        logic [PTR_W-1:0]                wptr;
        logic [PTR_W-1:0]                rptr;
        logic [CNT_W-1:0]                cnt;
        logic                            second;
        logic [DATA_W-1:0]               low;
        logic                            rv;
        logic [2*DATA_W-1:0]             rd;
        logic [TAG_W-1:0]                rt;
    } st_t;

    st_t  q, d;
    logic pop;

    always_comb begin
        d   = q;
        pop = qvld && q.second;

        if (issue_rd) begin
            d.tags[q.wptr] = issue_tag;
            d.wptr         = q.wptr + 1'b1;
        end
        if (pop)
            d.rptr = q.rptr + 1'b1;

        case ({issue_rd, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase

        if (qvld) begin
            d.second = !q.second;
            if (!q.second)
                d.low = dq_in;
        end

        d.rv = pop;
        if (pop) begin
            d.rd = {dq_in, q.low};
            d.rt = q.tags[q.rptr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tag_full  = (q.cnt == CNT_W'(TAG_DEPTH));
    assign rsp_valid = q.rv;
    assign rsp_data  = q.rd;
    assign rsp_tag   = q.rt;
endmodule

// File: rtl/b2sram_ctrl.sv
module b2sram_ctrl
    import b2sram_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 36,
    parameter int BYTE_W    = 9,
    parameter int TAG_W     = 4,
    parameter int TAG_DEPTH = 4,
    localparam int NBYTES   = DATA_W / BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*DATA_W-1:0] req_wdata,
    input  logic [2*NBYTES-1:0] req_wmask,
    input  logic [TAG_W-1:0]    req_tag,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic                sram_kslot,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_rd_n,
    output logic                sram_wr_n,
    output logic [DATA_W-1:0]   sram_dq_out,
    output logic                sram_dq_oe,
    output logic [NBYTES-1:0]   sram_bw_n,
    input  logic [DATA_W-1:0]   sram_dq_in,
    input  logic                sram_qvld
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        cmd_pins_t         cmd;
    } st_t;

    st_t  q, d;
    logic ok_rd, ok_wr, tag_full;
    logic take_rd, take_wr;

    assign req_ready = req_write ? ok_wr : ok_rd;
    assign take_rd   = req_valid && !req_write && ok_rd;
    assign take_wr   = req_valid && req_write && ok_wr;

    b2sram_sched #(
        .WR_LAT (WR_GAP_SLOTS),
        .RD_LAT (RD_GAP_SLOTS)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_full (tag_full),
        .issue_rd (take_rd),
        .issue_wr (take_wr),
        .ok_rd    (ok_rd),
        .ok_wr    (ok_wr),
        .kslot    (sram_kslot)
    );

    b2sram_wrpipe #(
        .DATA_W (DATA_W),
        .NBYTES (NBYTES),
        .WR_LAT (WR_GAP_SLOTS)
    ) u_wrpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_wr (take_wr),
        .wdata    (req_wdata),
        .wmask    (req_wmask),
        .dq_out   (sram_dq_out),
        .dq_oe    (sram_dq_oe),
        .bw_n     (sram_bw_n)
    );

    b2sram_rdcap #(
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .TAG_DEPTH (TAG_DEPTH)
    ) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_rd  (take_rd),
        .issue_tag (req_tag),
        .dq_in     (sram_dq_in),
        .qvld      (sram_qvld),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_tag   (rsp_tag),
        .tag_full  (tag_full)
    );

    always_comb begin
        d          = q;
        d.cmd.rd_n = !take_rd;
        d.cmd.wr_n = !take_wr;
        if (take_rd || take_wr)
            d.addr = req_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.addr     <= '0;
            q.cmd.rd_n <= 1'b1;
            q.cmd.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sram_addr = q.addr;
    assign sram_rd_n = q.cmd.rd_n;
    assign sram_wr_n = q.cmd.wr_n;
endmodule

// File: rtl/b2sram_chk.sv
module b2sram_chk #(
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              sram_kslot,
    input logic              sram_rd_n,
    input logic              sram_wr_n,
    input logic              sram_dq_oe,
    input logic [NBYTES-1:0] sram_bw_n,
    input logic              sram_qvld,
    input logic              rsp_valid
);
    AST_CMD_ON_KSLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_rd_n || !sram_wr_n) |-> sram_kslot); // R2
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_rd_n && !sram_wr_n)); // R2
    AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_rd_n || !sram_wr_n) |=> (sram_rd_n && sram_wr_n)); // R2
    AST_WR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_wr_n |-> ##2 sram_dq_oe ##1 sram_dq_oe); // R3
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_dq_oe |-> (&sram_bw_n)); // R4
    AST_RSP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(sram_qvld)); // R5
    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !sram_qvld); // R7
    AST_GAP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !$past(sram_qvld)); // R7
    AST_GAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_qvld |-> !$past(sram_dq_oe)); // R7
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (sram_rd_n && sram_wr_n)); // R9
endmodule

bind b2sram_ctrl b2sram_chk #(.NBYTES(NBYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .sram_kslot (sram_kslot),
    .sram_rd_n  (sram_rd_n),
    .sram_wr_n  (sram_wr_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_bw_n  (sram_bw_n),
    .sram_qvld  (sram_qvld),
    .rsp_valid  (rsp_valid)
);

// File: tb/b2sram_ctrl_tb.sv
module b2sram_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 36;
    localparam int BW = 9;
    localparam int NB = DW / BW;
    localparam int TW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [2*DW-1:0]   req_wdata = '0;
    logic [2*NB-1:0]   req_wmask = '0;
    logic [TW-1:0]     req_tag = '0;
    logic              rsp_valid;
    logic [2*DW-1:0]   rsp_data;
    logic [TW-1:0]     rsp_tag;
    logic              sram_kslot;
    logic [AW-1:0]     sram_addr;
    logic              sram_rd_n, sram_wr_n, sram_dq_oe;
    logic [DW-1:0]     sram_dq_out;
    logic [NB-1:0]     sram_bw_n;
    logic [DW-1:0]     sram_dq_in = '0;
    logic              sram_qvld = 1'b0;

    always #4 clk = ~clk;

    b2sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .TAG_W(TW), .TAG_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .sram_kslot(sram_kslot), .sram_addr(sram_addr), .sram_rd_n(sram_rd_n),
        .sram_wr_n(sram_wr_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_bw_n(sram_bw_n), .sram_dq_in(sram_dq_in), .sram_qvld(sram_qvld)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [TW-1:0] next_tag = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // bench reference contents and memory model contents
    logic [2*DW-1:0] gold [0:(1<<AW)-1];
    logic [2*DW-1:0] mem  [0:(1<<AW)-1];

    // per-slot schedules of the memory model, indexed by slot mod 16
    bit            rs_v [0:15];
    logic [AW-1:0] rs_a [0:15];
    bit            rs_b [0:15];
    bit            ws_v [0:15];
    logic [AW-1:0] ws_a [0:15];
    bit            ws_b [0:15];
    bit            prev_oe = 1'b0;
    bit            prev_qv = 1'b0;

    // expected responses
    logic [TW-1:0]   ex_tag  [0:63];
    logic [2*DW-1:0] ex_data [0:63];
    int              ex_cyc  [0:63];
    int ex_wr = 0;
    int ex_rd = 0;

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            gold[i] = '0;
            mem[i]  = '0;
        end
        for (int i = 0; i < 16; i++) begin
            rs_v[i] = 1'b0; ws_v[i] = 1'b0;
            rs_a[i] = '0; ws_a[i] = '0; rs_b[i] = 1'b0; ws_b[i] = 1'b0;
        end
    end

    // memory model: drives returned beats, takes write beats, judges bus direction per slot
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int idx = cyc % 16;
            if (rs_v[idx]) begin
                sram_qvld  = 1'b1;
                sram_dq_in = rs_b[idx] ? mem[rs_a[idx]][2*DW-1:DW] : mem[rs_a[idx]][DW-1:0];
                rs_v[idx]  = 1'b0;
            end else begin
                sram_qvld  = 1'b0;
                sram_dq_in = '0;
            end
            if (ws_v[idx]) begin
                checks++;
                if (!sram_dq_oe) begin
                    errors++;
                    $display("FAIL R3 write beat slot %0d: dq_oe=%0b expected 1", cyc, sram_dq_oe);
                end else begin
                    for (int b = 0; b < NB; b++)
                        if (!sram_bw_n[b])
                            mem[ws_a[idx]][(ws_b[idx] ? DW : 0) + b*BW +: BW] = sram_dq_out[b*BW +: BW];
                end
                ws_v[idx] = 1'b0;
            end else if (sram_dq_oe) begin
                checks++; errors++;
                $display("FAIL R3 unexpected drive slot %0d: dq_oe=1 expected 0", cyc);
            end
            if ((sram_dq_oe && sram_qvld) || (sram_dq_oe && prev_qv) || (sram_qvld && prev_oe)) begin
                checks++; errors++;
                $display("FAIL R7 bus direction slot %0d: oe=%0b qvld=%0b prev_oe=%0b prev_qvld=%0b expected no adjacency",
                         cyc, sram_dq_oe, sram_qvld, prev_oe, prev_qv);
            end
            prev_oe = sram_dq_oe;
            prev_qv = sram_qvld;
            if (!sram_rd_n && sram_kslot) begin
                rs_v[(cyc+5)%16] = 1'b1; rs_a[(cyc+5)%16] = sram_addr; rs_b[(cyc+5)%16] = 1'b0;
                rs_v[(cyc+6)%16] = 1'b1; rs_a[(cyc+6)%16] = sram_addr; rs_b[(cyc+6)%16] = 1'b1;
            end
            if (!sram_wr_n && sram_kslot) begin
                ws_v[(cyc+2)%16] = 1'b1; ws_a[(cyc+2)%16] = sram_addr; ws_b[(cyc+2)%16] = 1'b0;
                ws_v[(cyc+3)%16] = 1'b1; ws_a[(cyc+3)%16] = sram_addr; ws_b[(cyc+3)%16] = 1'b1;
            end
        end
    end

    // response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (ex_rd == ex_wr) begin
                errors++;
                $display("FAIL R6 response with none outstanding: tag=%0d expected none", rsp_tag);
            end else begin
                if (rsp_tag !== ex_tag[ex_rd % 64]) begin
                    errors++;
                    $display("FAIL R6 tag: got %0d expected %0d", rsp_tag, ex_tag[ex_rd % 64]);
                end
                if (rsp_data !== ex_data[ex_rd % 64]) begin
                    errors++;
                    $display("FAIL R5 data: got %h expected %h", rsp_data, ex_data[ex_rd % 64]);
                end
                if (cyc != ex_cyc[ex_rd % 64] + 8) begin
                    errors++;
                    $display("FAIL R5 latency: got cycle %0d expected %0d", cyc, ex_cyc[ex_rd % 64] + 8);
                end
                ex_rd++;
            end
        end
    end

    task automatic check(input bit ok, input string what, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [2*DW-1:0] dat,
                        input logic [2*NB-1:0] m, output int acc);
        bit got = 1'b0;
        while (!got) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = wr; req_addr = a;
            req_wdata = dat; req_wmask = m; req_tag = next_tag;
            #1;
            if (req_ready) begin
                got = 1'b1;
                acc = cyc;
                if (wr) begin
                    for (int i = 0; i < 2*NB; i++)
                        if (m[i]) gold[a][i*BW +: BW] = dat[i*BW +: BW];
                end else begin
                    ex_tag[ex_wr % 64]  = next_tag;
                    ex_data[ex_wr % 64] = gold[a];
                    ex_cyc[ex_wr % 64]  = cyc;
                    ex_wr++;
                end
                next_tag = next_tag + 1'b1;
                @(posedge clk);
            end
        end
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        drop();
        repeat (20) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(sram_rd_n && sram_wr_n && !sram_dq_oe && (&sram_bw_n) && !rsp_valid,
              "R1 idle pins after reset", {sram_rd_n, sram_wr_n, sram_dq_oe, rsp_valid}, 4'b1100);
    endtask

    task automatic t_write_read();
        int a0, a1;
        send(1'b1, 8'd3, {36'h0_1234_5678, 36'h9_ABCD_EF01}, '1, a0);
        drop();
        repeat (6) @(posedge clk);
        send(1'b0, 8'd3, '0, '0, a1);
        settle();
        check(ex_rd == ex_wr, "R3 R5 write then read answered", ex_rd, ex_wr);
    endtask

    task automatic t_mask();
        int a;
        send(1'b1, 8'd5, {36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF}, '1, a);
        send(1'b1, 8'd5, {36'h1_2345_6789, 36'hA_BCDE_F012}, 8'b0101_1010, a);
        send(1'b0, 8'd5, '0, '0, a);
        settle();
        check(ex_rd == ex_wr, "R4 masked write read back", ex_rd, ex_wr);
    endtask

    task automatic t_stream();
        int acc [4];
        for (int i = 0; i < 4; i++) begin
            int a;
            send(1'b1, AW'(16 + i), {36'(i * 7 + 1), 36'(i * 13 + 2)}, '1, a);
        end
        for (int i = 0; i < 4; i++)
            send(1'b0, AW'(16 + i), '0, '0, acc[i]);
        settle();
        for (int i = 1; i < 4; i++)
            check(acc[i] - acc[i-1] == 2, "R8 read accept spacing", acc[i] - acc[i-1], 2);
        check(ex_rd == ex_wr, "R6 all stream reads answered in order", ex_rd, ex_wr);
    endtask

    task automatic t_turn();
        int r0, w0, w1, r1;
        send(1'b0, 8'd3, '0, '0, r0);
        send(1'b1, 8'd40, {36'h5_5555_5555, 36'hA_AAAA_AAAA}, '1, w0);
        check(w0 - r0 == 6, "R7 read-to-write accept spacing", w0 - r0, 6);
        settle();
        send(1'b1, 8'd41, {36'h3_3333_3333, 36'hC_CCCC_CCCC}, '1, w1);
        send(1'b0, 8'd41, '0, '0, r1);
        check(r1 - w1 == 2, "R7 write-to-read accept spacing", r1 - w1, 2);
        send(1'b0, 8'd40, '0, '0, r1);
        settle();
        check(ex_rd == ex_wr, "R7 reads around turnaround answered", ex_rd, ex_wr);
    endtask

    task automatic t_kslot();
        @(negedge clk);
        while (!sram_kslot) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wmask = '1; req_addr = 8'd60;
        #1;
        check(!req_ready, "R2 ready in complementary slot", req_ready, 0);
        req_write = 1'b0;
        #1;
        check(!req_ready, "R2 read ready in complementary slot", req_ready, 0);
        @(posedge clk);
        #1;
        check(sram_rd_n && sram_wr_n, "R2 no command after refused slot", {sram_rd_n, sram_wr_n}, 2'b11);
        settle();
    endtask

    task automatic t_idle();
        bit bad = 1'b0;
        int a;
        drop();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!sram_rd_n || !sram_wr_n || sram_dq_oe) bad = 1'b1;
        end
        check(!bad, "R9 no command during long idle", bad, 0);
        send(1'b1, 8'd9, {36'h7_0F0F_0F0F, 36'h0_F0F0_F0F0}, '1, a);
        send(1'b0, 8'd9, '0, '0, a);
        settle();
        check(ex_rd == ex_wr, "R9 resume after idle", ex_rd, ex_wr);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(sram_rd_n && sram_wr_n && !sram_dq_oe && (&sram_bw_n) && !rsp_valid,
              "R1 idle pins during reset", {sram_rd_n, sram_wr_n, sram_dq_oe, rsp_valid}, 4'b1100);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_mask();
        t_stream();
        t_turn();
        t_kslot();
        t_idle();
        check(ex_rd == ex_wr, "R6 no response missing at end", ex_rd, ex_wr);
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, cycle %0d expected below 50000", cyc);
            finish_up();
        end
    end
endmodule